// File: doc/BRIEF.md
# Register-Mapped General-Purpose Pin Controller

This block owns 54 general-purpose pins and exposes them to software through a word-addressed register window on a simple 32-bit bus. The bus carries an address, write data, a write strobe, a read strobe and read data. For each pin, software picks one of eight functions: input, output, or one of six alternate functions. When a pin is in output mode the block drives the pad from its own output latch. In every other mode it passes through data supplied by the peripheral that owns the alternate function.

Output levels never change through a read-modify-write. Software writes ones to a set word or to a clear word, and only the addressed pins move. Input levels reach software through two read-only level words, after a two-stage synchronizer. Pull resistors are configured in two steps. Software first writes a control code. It then raises per-pin clock bits, and a pin takes the code on the 0-to-1 transition of its stored clock bit.

The bus address is a word index, so byte offset = 4 × index:

| Word index | Content |
|---|---|
| 0..5 | function words |
| 7..8 | set words |
| 10..11 | clear words |
| 13..14 | level words |
| 37 | pull control |
| 38..39 | pull clock words |

Top module: `gpio_bank_ctrl`

## Requirements
- R1: While `rst_n` is low, all function fields are 000 (input), all output latches are 0, all pull states are 00, `pad_oe` is all zero and `bus_rdata` is zero. These values take effect immediately, and the internal reset is released two clock edges after `rst_n` rises.
- R2: Pin p's 3-bit function field sits in function word p/10 (word index 0..5) at bits (p%10)*3+2:(p%10)*3. It reads back there and appears on `fsel_out[3p+2:3p]` one edge after the write.
- R3: The function codes are: input 000, output 001, alternate 0..3 = 100, 101, 110, 111, alternate 4 = 011, alternate 5 = 010. `pad_oe[p]` is 1 exactly when pin p's code is 001. `pad_out[p]` equals the output latch in that case and `alt_out[p]` otherwise.
- R4: A write to set word k (index 7+k) sets the output latch of pin 32k+b for every 1 in bit b. Bits written as 0 leave their latches unchanged.
- R5: A write to clear word k (index 10+k) clears the output latch of pin 32k+b for every 1 in bit b. Bits written as 0 leave their latches unchanged.
- R6: Level word k (index 13+k) returns the input level of pin 32k+b in bit b, after two synchronizer flops. A change on `pin_in` first appears in a read whose strobe is sampled at the third rising edge after the change.
- R7: The pull control word (index 37) holds code 00 none, 01 up, 10 down in bits 1:0. Pull clock word k (index 38+k) is read/write. A pin loads the control value held before the edge, one edge after its stored clock bit goes 0 to 1. A clock bit that stays high does not reload the pin, and pins whose clock bit does not rise keep their state.
- R8: Reads of the set words, the clear words and unmapped indices return zero.
- R9: Bits for pin numbers above 53 are not stored and read back as zero. Function word 5 keeps only bits 11:0, and pull clock word 1 and level word 1 keep only bits 21:0.
- R10: `bus_rdata` is registered. It loads the addressed word on an edge where `bus_re` is high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Word index of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 54 | Pad input levels, asynchronous |
| alt_out | input | 54 | Output data from alternate-function peripherals |
| pad_out | output | 54 | Pad output data |
| pad_oe | output | 54 | Pad output enable |
| fsel_out | output | 162 | Function code per pin, 3 bits each |
| pull_state | output | 108 | Latched pull code per pin, 2 bits each |

## Verification
Two functions can land on the same clock edge: the delayed load of a pull state after a clock bit rises, and a new write to the pull control word. The bench provokes this by writing the control word in the cycle that directly follows the clock-bit write. That is exactly the edge where the pin loads its state. The pin must hold the code that was programmed before that edge, not the new one, and a later control change while the clock bit stays high must leave it alone. Read-data timing is judged the same way: the level synchronizer's latency is checked with back-to-back reads, which must return 0, 0 and then 1.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int WORD_W      = 32;
  localparam int PINS_PER_FN = 10;
  localparam int FN_W        = 3;
  localparam int PULL_W      = 2;

  // word indices on the bus
  localparam int A_FSEL_BASE = 0;
  localparam int A_SET_BASE  = 7;
  localparam int A_CLR_BASE  = 10;
  localparam int A_LVL_BASE  = 13;
  localparam int A_PCTL      = 37;
  localparam int A_PCLK_BASE = 38;

  typedef enum logic [2:0] {
    FN_INPUT  = 3'b000,
    FN_OUTPUT = 3'b001,
    FN_ALT0   = 3'b100,
    FN_ALT1   = 3'b101,
    FN_ALT2   = 3'b110,
    FN_ALT3   = 3'b111,
    FN_ALT4   = 3'b011,
    FN_ALT5   = 3'b010
  } fn_code_e;

  typedef enum logic [1:0] {
    PULL_NONE = 2'b00,
    PULL_UP   = 2'b01,
    PULL_DOWN = 2'b10
  } pull_code_e;
endpackage

// File: rtl/gpio_fsel_regs.sv
module gpio_fsel_regs
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 54,
  parameter int ADDR_W   = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [WORD_W-1:0]        wr_data,
  output logic [WORD_W-1:0]        rd_data,
  output logic [NUM_PINS*FN_W-1:0] fsel_flat
);
  logic [FN_W-1:0] fsel_q [NUM_PINS];
  logic [FN_W-1:0] fsel_d [NUM_PINS];

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam int WIDX = p / PINS_PER_FN;
    localparam int BOFS = (p % PINS_PER_FN) * FN_W;
    logic hit;
    assign hit = wr_en && (addr == ADDR_W'(A_FSEL_BASE + WIDX));

    always_comb begin
      fsel_d[p] = fsel_q[p];
      if (hit) fsel_d[p] = wr_data[BOFS +: FN_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   fsel_q[p] <= FN_INPUT;
      else if (hit) fsel_q[p] <= fsel_d[p];
    end

    assign fsel_flat[p*FN_W +: FN_W] = fsel_q[p];
  end

  always_comb begin
    rd_data = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (addr == ADDR_W'(A_FSEL_BASE + p / PINS_PER_FN))
        rd_data[(p % PINS_PER_FN) * FN_W +: FN_W] = fsel_q[p];
    end
  end
endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 54,
  parameter int ADDR_W   = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [WORD_W-1:0]   wr_data,
  output logic [NUM_PINS-1:0] out_q
);
  logic [NUM_PINS-1:0] set_mask;
  logic [NUM_PINS-1:0] clr_mask;
  logic [NUM_PINS-1:0] out_d;
  logic                out_en;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam int BANK = p / WORD_W;
    localparam int BIT  = p % WORD_W;
    assign set_mask[p] = wr_en && (addr == ADDR_W'(A_SET_BASE + BANK)) && wr_data[BIT];
    assign clr_mask[p] = wr_en && (addr == ADDR_W'(A_CLR_BASE + BANK)) && wr_data[BIT];
  end

  always_comb begin
    out_en = |(set_mask | clr_mask);
    out_d  = (out_q | set_mask) & ~clr_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      out_q <= '0;
    else if (out_en) out_q <= out_d;
  end
endmodule

// File: rtl/gpio_pull_latch.sv
module gpio_pull_latch
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 54,
  parameter int ADDR_W   = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [WORD_W-1:0]          wr_data,
  output logic [WORD_W-1:0]          rd_data,
  output logic [NUM_PINS*PULL_W-1:0] pull_flat
);
  logic [PULL_W-1:0]   ctl_q, ctl_d;
  logic                ctl_en;
  logic [NUM_PINS-1:0] pclk_q, pclk_d, pclk_prev;
  logic [NUM_PINS-1:0] pclk_en;
  logic [NUM_PINS-1:0] rise;
  logic [PULL_W-1:0]   pull_q [NUM_PINS];

  always_comb begin
    ctl_en = wr_en && (addr == ADDR_W'(A_PCTL));
    ctl_d  = wr_data[PULL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= PULL_NONE;
    else if (ctl_en) ctl_q <= ctl_d;
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam int BANK = p / WORD_W;
    localparam int BIT  = p % WORD_W;
    assign pclk_en[p] = wr_en && (addr == ADDR_W'(A_PCLK_BASE + BANK));
    assign pclk_d[p]  = wr_data[BIT];
    assign rise[p]    = pclk_q[p] & ~pclk_prev[p];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pclk_q[p]    <= 1'b0;
        pclk_prev[p] <= 1'b0;
        pull_q[p]    <= PULL_NONE;
      end else begin
        if (pclk_en[p]) pclk_q[p] <= pclk_d[p];
        pclk_prev[p] <= pclk_q[p];
        if (rise[p]) pull_q[p] <= ctl_q;
      end
    end

    assign pull_flat[p*PULL_W +: PULL_W] = pull_q[p];
  end

  always_comb begin
    rd_data = '0;
    if (addr == ADDR_W'(A_PCTL)) rd_data[PULL_W-1:0] = ctl_q;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (addr == ADDR_W'(A_PCLK_BASE + p / WORD_W))
        rd_data[p % WORD_W] = pclk_q[p];
    end
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int NUM_PINS = 54
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] level
);
  logic [NUM_PINS-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      level  <= '0;
    end else begin
      stage1 <= pin_in;
      level  <= stage1;
    end
  end
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 54,
  parameter int ADDR_W   = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [WORD_W-1:0]          bus_wdata,
  input  logic                       bus_we,
  input  logic                       bus_re,
  output logic [WORD_W-1:0]          bus_rdata,
  input  logic [NUM_PINS-1:0]        pin_in,
  input  logic [NUM_PINS-1:0]        alt_out,
  output logic [NUM_PINS-1:0]        pad_out,
  output logic [NUM_PINS-1:0]        pad_oe,
  output logic [NUM_PINS*FN_W-1:0]   fsel_out,
  output logic [NUM_PINS*PULL_W-1:0] pull_state
);
  logic [1:0]          rst_pipe;
  logic                rst_int_n;
  logic [WORD_W-1:0]   fsel_rd, pull_rd, lvl_rd;
  logic [WORD_W-1:0]   rdata_d, rdata_q;
  logic [NUM_PINS-1:0] out_q;
  logic [NUM_PINS-1:0] level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  gpio_fsel_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_fsel (
    .clk(clk), .rst_n(rst_int_n), .wr_en(bus_we), .addr(bus_addr),
    .wr_data(bus_wdata), .rd_data(fsel_rd), .fsel_flat(fsel_out)
  );

  gpio_out_latch #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_out (
    .clk(clk), .rst_n(rst_int_n), .wr_en(bus_we), .addr(bus_addr),
    .wr_data(bus_wdata), .out_q(out_q)
  );

  gpio_pull_latch #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_pull (
    .clk(clk), .rst_n(rst_int_n), .wr_en(bus_we), .addr(bus_addr),
    .wr_data(bus_wdata), .rd_data(pull_rd), .pull_flat(pull_state)
  );

  gpio_in_sync #(.NUM_PINS(NUM_PINS)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .pin_in(pin_in), .level(level)
  );

  always_comb begin
    lvl_rd = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (bus_addr == ADDR_W'(A_LVL_BASE + p / WORD_W))
        lvl_rd[p % WORD_W] = level[p];
    end
  end

  always_comb begin
    rdata_d = fsel_rd | pull_rd | lvl_rd;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  rdata_q <= '0;
    else if (bus_re) rdata_q <= rdata_d;
  end
  assign bus_rdata = rdata_q;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pad
    assign pad_oe[p]  = (fsel_out[p*FN_W +: FN_W] == FN_OUTPUT);
    assign pad_out[p] = pad_oe[p] ? out_q[p] : alt_out[p];
  end
endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 54,
  parameter int ADDR_W   = 6
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [ADDR_W-1:0]          bus_addr,
  input logic [WORD_W-1:0]          bus_wdata,
  input logic                       bus_we,
  input logic                       bus_re,
  input logic [WORD_W-1:0]          bus_rdata,
  input logic [NUM_PINS-1:0]        pad_oe,
  input logic [NUM_PINS*FN_W-1:0]   fsel_flat,
  input logic [NUM_PINS-1:0]        out_q,
  input logic [NUM_PINS*PULL_W-1:0] pull_flat
);
  logic set_wr0, clr_wr0, outreg_wr, pclk_wr, wo_rd;

  always_comb begin
    set_wr0   = bus_we && (bus_addr == ADDR_W'(A_SET_BASE));
    clr_wr0   = bus_we && (bus_addr == ADDR_W'(A_CLR_BASE));
    outreg_wr = bus_we && (bus_addr >= ADDR_W'(A_SET_BASE)) && (bus_addr <= ADDR_W'(A_CLR_BASE + 1));
    pclk_wr   = bus_we && (bus_addr >= ADDR_W'(A_PCLK_BASE)) && (bus_addr <= ADDR_W'(A_PCLK_BASE + 1));
    wo_rd     = bus_re && (bus_addr >= ADDR_W'(A_SET_BASE)) && (bus_addr <= ADDR_W'(A_CLR_BASE + 1));
  end

  assert_set_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    set_wr0 |=> ((out_q[WORD_W-1:0] & $past(bus_wdata)) == $past(bus_wdata)));

  assert_clr_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr0 |=> ((out_q[WORD_W-1:0] & $past(bus_wdata)) == '0));

  assert_out_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !outreg_wr |=> $stable(out_q));

  assert_pull_needs_clk_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pull_flat) |-> $past(pclk_wr, 2));

  assert_wo_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wo_rd |=> (bus_rdata == '0));

  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> $stable(bus_rdata));

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_oe
    assert_oe_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pad_oe[p] == (fsel_flat[p*FN_W +: FN_W] == FN_OUTPUT));
  end
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .pad_oe(pad_oe),
  .fsel_flat(fsel_out), .out_q(out_q), .pull_flat(pull_state)
);

// File: tb/tb_gpio_bank_ctrl.sv
module tb_gpio_bank_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 54;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] bus_addr;
  logic [31:0]   bus_wdata;
  logic          bus_we, bus_re;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pin_in, alt_out, pad_out, pad_oe;
  logic [NP*3-1:0] fsel_out;
  logic [NP*2-1:0] pull_state;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_bank_ctrl #(.NUM_PINS(NP), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .alt_out(alt_out), .pad_out(pad_out), .pad_oe(pad_oe),
    .fsel_out(fsel_out), .pull_state(pull_state)
  );

  // {read, addr, data, expected}
  localparam int NV = 17;
  localparam logic [70:0] VEC [NV] = '{
    {1'b0, 6'd1,  32'h0000_0008, 32'h0},          // R2 pin 11 -> output
    {1'b1, 6'd1,  32'h0,         32'h0000_0008},  // R2
    {1'b0, 6'd5,  32'hFFFF_FFFF, 32'h0},          // R9
    {1'b1, 6'd5,  32'h0,         32'h0000_0FFF},  // R9 only pins 50..53 kept
    {1'b0, 6'd5,  32'h0,         32'h0},
    {1'b1, 6'd5,  32'h0,         32'h0},
    {1'b1, 6'd7,  32'h0,         32'h0},          // R8 set word
    {1'b1, 6'd11, 32'h0,         32'h0},          // R8 clear word
    {1'b1, 6'd6,  32'h0,         32'h0},          // R8 unmapped
    {1'b1, 6'd20, 32'h0,         32'h0},          // R8 unmapped
    {1'b0, 6'd37, 32'hFFFF_FFFF, 32'h0},          // R7 control width
    {1'b1, 6'd37, 32'h0,         32'h0000_0003},
    {1'b0, 6'd37, 32'h0,         32'h0},
    {1'b0, 6'd39, 32'hFFFF_FFFF, 32'h0},          // R9 pull clock word 1
    {1'b1, 6'd39, 32'h0,         32'h003F_FFFF},
    {1'b0, 6'd39, 32'h0,         32'h0},
    {1'b0, 6'd1,  32'h0,         32'h0}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // tasks are entered just after a falling edge
  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_we = 1'b0; bus_re = 1'b0;
    pin_in = '0; alt_out = '0;
    idle(3);
    // R1 reset state
    check("R1 fsel", 64'(fsel_out == '0), 64'd1);
    check("R1 oe", 64'(pad_oe), 64'd0);
    check("R1 pull", 64'(pull_state == '0), 64'd1);
    check("R1 rdata", 64'(bus_rdata), 64'd0);
    rst_n = 1'b1;
    idle(3);

    // table walk (R2, R7, R8, R9)
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][70]) begin
        rd(VEC[i][69:64], r);
        check($sformatf("table R2/R7/R8/R9 entry %0d", i), 64'(r), 64'(VEC[i][31:0]));
      end else begin
        wr(VEC[i][69:64], VEC[i][63:32]);
      end
    end

    // R2/R3 pin1 output (001), pin2 alt0 (100)
    wr(6'd0, 32'h0000_0108);
    check("R2 pin1 code", 64'(fsel_out[5:3]), 64'd1);
    check("R2 pin2 code", 64'(fsel_out[8:6]), 64'd4);
    check("R3 oe", 64'(pad_oe), 64'h2);
    // R4 set pins 1,2
    wr(6'd7, 32'h0000_0006);
    check("R4 pin1 driven", 64'(pad_out[1]), 64'd1);
    check("R3 pin2 follows alt", 64'(pad_out[2]), 64'd0);
    alt_out[2] = 1'b1; #1;
    check("R3 pin2 follows alt high", 64'(pad_out[2]), 64'd1);
    alt_out[2] = 1'b0;
    wr(6'd0, 32'h0000_0048);  // pin2 -> output
    check("R3 pin2 from latch", 64'(pad_out[2]), 64'd1);
    // R5 clear pin1 only
    wr(6'd10, 32'h0000_0002);
    check("R5 pin1 cleared", 64'(pad_out[1]), 64'd0);
    check("R5 pin2 kept", 64'(pad_out[2]), 64'd1);
    wr(6'd7, 32'h0);
    check("R4 zero write no effect", 64'(pad_out[2:1]), 64'd2);
    // upper bank, pin 53
    wr(6'd5, 32'h0000_0200);
    wr(6'd8, 32'h0020_0000);
    check("R4 pin53 set", 64'(pad_out[53]), 64'd1);
    wr(6'd11, 32'hFFC0_0000);
    check("R5 pin53 unaffected by high bits", 64'(pad_out[53]), 64'd1);
    wr(6'd11, 32'h0020_0000);
    check("R5 pin53 cleared", 64'(pad_out[53]), 64'd0);

    // R6 synchronizer latency
    pin_in[5] = 1'b1;
    rd(6'd13, r); check("R6 lvl edge1", 64'(r[5]), 64'd0);
    rd(6'd13, r); check("R6 lvl edge2", 64'(r[5]), 64'd0);
    rd(6'd13, r); check("R6 lvl edge3", 64'(r[5]), 64'd1);
    pin_in = '1;
    idle(3);
    rd(6'd14, r); check("R6/R9 lvl word1", 64'(r), 64'h003F_FFFF);
    pin_in = '0;

    // R10 hold when not reading
    bus_addr = 6'd13; idle(4);
    check("R10 rdata held", 64'(bus_rdata), 64'h003F_FFFF);

    // R7 pull sequence; control rewrite lands on the load edge
    wr(6'd37, 32'h1);
    wr(6'd38, 32'h0000_0008);
    wr(6'd37, 32'h0);
    check("R7 pin3 up", 64'(pull_state[7:6]), 64'd1);
    check("R7 pin4 untouched", 64'(pull_state[9:8]), 64'd0);
    wr(6'd38, 32'h0);
    wr(6'd37, 32'h2);
    wr(6'd38, 32'h0000_0008);
    wr(6'd37, 32'h1);
    idle(2);
    check("R7 pin3 down, no reload while high", 64'(pull_state[7:6]), 64'd2);
    wr(6'd38, 32'h0);
    wr(6'd39, 32'h0000_0100);  // pin 40 with control 01
    wr(6'd37, 32'h0);
    check("R7 pin40 up", 64'(pull_state[81:80]), 64'd1);
    check("R7 pin3 kept", 64'(pull_state[7:6]), 64'd2);

    // R1 asynchronous reset mid-run
    #2 rst_n = 1'b0; #1;
    check("R1 async fsel", 64'(fsel_out == '0), 64'd1);
    check("R1 async pull", 64'(pull_state == '0), 64'd1);
    check("R1 async oe", 64'(pad_oe), 64'd0);
    idle(2);
    rst_n = 1'b1;
    idle(3);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule